// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt request lines, chooses the most urgent unmasked one, and signals the processor on a single interrupt output. Software reaches it through an 8-bit register port with two addresses. The command address carries initialization, end-of-interrupt and status-selection bytes. The data address carries the remaining initialization words and the mask register. The processor answers an interrupt with two acknowledge pulses. The first pulse moves the winning request into service. The second pulse returns an 8-bit vector: the programmed base with the level number in its low three bits.

Two instances can be chained to serve fifteen sources. On the master, a cascade bit map marks the inputs that have a slave attached. When such an input wins, the master drives that input's number on the cascade lines and does not return a vector itself. The slave whose programmed identity matches the cascade lines answers the acknowledge pulses and supplies the vector. The role of each instance comes from the `slaveMode` pin.

After any initialization, no interrupt is raised until the initialization sequence has finished. Requests are edge-sensitive unless level sensing is chosen during initialization. End-of-interrupt is either a specific command or automatic at the end of the acknowledge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A command-address write with bit 4 set (for example 0x11) starts initialization. On the next cycle the mask register is 0xFF, every in-service bit is clear, and status reads select the request register. `irqOut` stays low until the initialization sequence completes.
- R2: In that first byte, bit 0 set means a mode word follows, bit 1 set means single (no cascade), and bit 3 set means level sensing. The following data-address writes are taken in this order: vector base (bits 7:3 used), cascade word (skipped in single mode), then mode word (only when bit 0 was set). The first data write after the sequence loads the mask.
- R3: Outside initialization, a data-address write (`addr`=1) loads the mask, and a read at `addr`=1 returns it. A mask bit of 1 blocks that level. The mask is 0xFF after reset.
- R4: Command byte 0x0A makes reads at `addr`=0 return the request register, and command byte 0x0B makes them return the in-service register. After reset the request register is selected.
- R5: `irqOut` is high exactly when an unmasked request is pending and no in-service bit is set at that level or at a more urgent one. Level 0 is the most urgent.
- R6: On the first acknowledge pulse, the winning level's in-service bit is set and, in edge mode, its request bit is cleared. The second pulse raises `vecValid` with `vecOut` = {base[7:3], level}.
- R7: Command byte 0x60+n (n from 0 to 7) clears in-service bit n and no other bit.
- R8: When bit 1 of the mode word is set (automatic end-of-interrupt), the in-service bit of the acknowledged level is cleared at the second acknowledge pulse.
- R9: If no eligible request exists at the first acknowledge pulse, the controller returns the level-7 vector on the second pulse and leaves the in-service register unchanged, whatever the mask holds.
- R10: In edge mode, a request bit is set by a low-to-high transition and cleared when the line drops. A line held high after its acknowledge does not request again. In level mode, the request bit follows the line.
- R11: On a master that is not in single mode, if the cascade bit map has the winning level's bit set, `casDrive` is high with `casOut` = level during both pulses, and `vecValid` stays low.
- R12: With `slaveMode`=1, the low three bits of the cascade word are the identity. Acknowledge pulses have an effect only while `casIn` equals that identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | 1 | 0 selects the command address, 1 selects the data address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected address |
| irqReq | input | 8 | Interrupt request lines |
| irqOut | output | 1 | Interrupt request to the processor |
| intAck | input | 1 | Acknowledge pulse, one cycle each |
| vecOut | output | 8 | Vector returned on the second pulse |
| vecValid | output | 1 | `vecOut` is being supplied |
| slaveMode | input | 1 | 1 makes this instance a slave |
| casIn | input | 3 | Cascade identity seen by a slave |
| casOut | output | 3 | Cascade identity driven by a master |
| casDrive | output | 1 | `casOut` is valid |

## Verification
The assertions check these rules on every cycle:
- Initialization leaves the mask full and the in-service register empty, with the interrupt output low.
- A specific end-of-interrupt clears its bit.
- `irqOut` is high only while an unmasked request bit is set.
- A spurious acknowledge leaves the in-service register untouched.
- A vector appears only during an acknowledge pulse.

The bench scenarios cover what needs a history of inputs:
- the order of the initialization words and which of them are skipped
- nesting a more urgent request over a level already in service
- the exact vector values
- edge against level re-requesting
- automatic end-of-interrupt
- cascade identity driving
- a slave ignoring pulses meant for another identity

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LEVELS = 8;
  localparam int PIC_LVL_W  = $clog2(PIC_LEVELS);

  typedef enum logic [1:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CAS,
    CFG_MODE
  } cfg_state_e;

  typedef struct packed {
    logic                 initAll;
    logic                 loadMask;
    logic                 eoi;
    logic [PIC_LVL_W-1:0] eoiLevel;
    logic                 ackFirst;
    logic                 ackSecond;
  } pic_stb_t;
endpackage

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int N  = PIC_LEVELS,
  parameter int LW = PIC_LVL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  irqReq,
  input  logic [N-1:0]  wrData,
  input  pic_stb_t      stb,
  input  logic          levelTrig,
  input  logic          autoEoi,
  output logic [N-1:0]  irrQ,
  output logic [N-1:0]  isrQ,
  output logic [N-1:0]  maskQ,
  output logic          irqPend,
  output logic [LW-1:0] curLevel,
  output logic [LW-1:0] ackLevel,
  output logic          ackSpur
);
  logic [N-1:0] reqPrev;
  logic [N-1:0] pending;
  logic [N-1:0] covered;
  logic [N-1:0] irrNext;
  logic [N-1:0] isrNext;
  logic         blocked;

  assign pending = irrQ & ~maskQ;

  // Lowest-numbered pending level wins; it is blocked by any in-service bit at or above it.
  always_comb begin
    curLevel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) curLevel = LW'(i);
    end
    for (int i = 0; i < N; i++) begin
      covered[i] = (i <= int'(curLevel));
    end
    blocked = |(isrQ & covered);
    irqPend = (|pending) && !blocked;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      irrNext[i] = levelTrig ? irqReq[i] : (irqReq[i] & (irrQ[i] | ~reqPrev[i]));
    end
    if (stb.ackFirst && irqPend && !levelTrig) irrNext[curLevel] = 1'b0;
  end

  always_comb begin
    isrNext = isrQ;
    if (stb.ackFirst && irqPend) isrNext[curLevel] = 1'b1;
    if (stb.ackSecond && autoEoi && !ackSpur) isrNext[ackLevel] = 1'b0;
    if (stb.eoi) isrNext[stb.eoiLevel] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev  <= '0;
      irrQ     <= '0;
      isrQ     <= '0;
      maskQ    <= '1;
      ackLevel <= '1;
      ackSpur  <= 1'b1;
    end else begin
      reqPrev <= irqReq;
      if (stb.initAll) begin
        irrQ     <= '0;
        isrQ     <= '0;
        maskQ    <= '1;
        ackLevel <= '1;
        ackSpur  <= 1'b1;
      end else begin
        irrQ <= irrNext;
        isrQ <= isrNext;
        if (stb.loadMask) maskQ <= wrData;
        if (stb.ackFirst) begin
          ackLevel <= irqPend ? curLevel : '1;
          ackSpur  <= !irqPend;
        end
      end
    end
  end
endmodule

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
#(
  parameter int N  = PIC_LEVELS,
  parameter int LW = PIC_LVL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          addr,
  input  logic [N-1:0]  wrData,
  input  logic          intAck,
  input  logic          slaveMode,
  input  logic [LW-1:0] casIn,
  input  logic          irqPend,
  input  logic [LW-1:0] curLevel,
  input  logic [LW-1:0] ackLevel,
  input  logic          ackSpur,
  input  logic [N-1:0]  irrQ,
  input  logic [N-1:0]  isrQ,
  input  logic [N-1:0]  maskQ,
  output pic_stb_t      stb,
  output logic          levelTrig,
  output logic          autoEoi,
  output logic          irqOut,
  output logic [N-1:0]  rdData,
  output logic [N-1:0]  vecOut,
  output logic          vecValid,
  output logic [LW-1:0] casOut,
  output logic          casDrive
);
  localparam int EOI_OP  = 12;  // upper bits 01100 -> 0x60 + level
  localparam int SEL_IRR = 10;
  localparam int SEL_ISR = 11;

  cfg_state_e     state;
  logic           initDone, needMode, single, readIsr, ackPhase;
  logic [N-1:LW]  baseQ;
  logic [N-1:0]   casCfg;
  logic           cmdWr, dataWr, initCmd, accepted, masterCas;

  assign cmdWr     = wrEn && !addr;
  assign dataWr    = wrEn && addr;
  assign initCmd   = cmdWr && wrData[4];
  assign accepted  = initDone && (!slaveMode || casIn == casCfg[LW-1:0]);
  assign masterCas = !slaveMode && !single;

  always_comb begin
    stb.initAll   = initCmd;
    stb.loadMask  = dataWr && (state == CFG_IDLE);
    stb.eoi       = cmdWr && !wrData[4] && (wrData[N-1:LW] == (N-LW)'(EOI_OP));
    stb.eoiLevel  = wrData[LW-1:0];
    stb.ackFirst  = intAck && accepted && !ackPhase;
    stb.ackSecond = intAck && accepted && ackPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= CFG_IDLE;
      initDone  <= 1'b0;
      needMode  <= 1'b0;
      single    <= 1'b0;
      levelTrig <= 1'b0;
      autoEoi   <= 1'b0;
      readIsr   <= 1'b0;
      ackPhase  <= 1'b0;
      baseQ     <= '0;
      casCfg    <= '0;
    end else if (initCmd) begin
      state     <= CFG_BASE;
      initDone  <= 1'b0;
      needMode  <= wrData[0];
      single    <= wrData[1];
      levelTrig <= wrData[3];
      autoEoi   <= 1'b0;
      readIsr   <= 1'b0;
      ackPhase  <= 1'b0;
    end else begin
      if (dataWr) begin
        case (state)
          CFG_BASE: begin
            baseQ <= wrData[N-1:LW];
            if (!single) state <= CFG_CAS;
            else if (needMode) state <= CFG_MODE;
            else begin
              state    <= CFG_IDLE;
              initDone <= 1'b1;
            end
          end
          CFG_CAS: begin
            casCfg <= wrData;
            if (needMode) state <= CFG_MODE;
            else begin
              state    <= CFG_IDLE;
              initDone <= 1'b1;
            end
          end
          CFG_MODE: begin
            autoEoi  <= wrData[1];
            state    <= CFG_IDLE;
            initDone <= 1'b1;
          end
          default: ;
        endcase
      end
      if (cmdWr && wrData == N'(SEL_IRR)) readIsr <= 1'b0;
      if (cmdWr && wrData == N'(SEL_ISR)) readIsr <= 1'b1;
      if (stb.ackFirst) ackPhase <= 1'b1;
      if (stb.ackSecond) ackPhase <= 1'b0;
    end
  end

  assign irqOut   = initDone && irqPend;
  assign casOut   = ackPhase ? ackLevel : curLevel;
  assign casDrive = intAck && initDone && masterCas &&
                    (ackPhase ? (!ackSpur && casCfg[ackLevel]) : (irqPend && casCfg[curLevel]));
  assign vecValid = stb.ackSecond && !(masterCas && !ackSpur && casCfg[ackLevel]);
  assign vecOut   = {baseQ, ackLevel};
  assign rdData   = addr ? maskQ : (readIsr ? isrQ : irrQ);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import pic_pkg::*;
#(
  parameter int N  = PIC_LEVELS,
  parameter int LW = PIC_LVL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          addr,
  input  logic [N-1:0]  wrData,
  output logic [N-1:0]  rdData,
  input  logic [N-1:0]  irqReq,
  output logic          irqOut,
  input  logic          intAck,
  output logic [N-1:0]  vecOut,
  output logic          vecValid,
  input  logic          slaveMode,
  input  logic [LW-1:0] casIn,
  output logic [LW-1:0] casOut,
  output logic          casDrive
);
  pic_stb_t      stb;
  logic          levelTrig, autoEoi, irqPend, ackSpur;
  logic [LW-1:0] curLevel, ackLevel;
  logic [N-1:0]  irrQ, isrQ, maskQ;

  pic_control #(.N(N), .LW(LW)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .intAck(intAck), .slaveMode(slaveMode), .casIn(casIn),
    .irqPend(irqPend), .curLevel(curLevel), .ackLevel(ackLevel), .ackSpur(ackSpur),
    .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ),
    .stb(stb), .levelTrig(levelTrig), .autoEoi(autoEoi), .irqOut(irqOut),
    .rdData(rdData), .vecOut(vecOut), .vecValid(vecValid),
    .casOut(casOut), .casDrive(casDrive)
  );

  pic_datapath #(.N(N), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .wrData(wrData), .stb(stb),
    .levelTrig(levelTrig), .autoEoi(autoEoi),
    .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ), .irqPend(irqPend),
    .curLevel(curLevel), .ackLevel(ackLevel), .ackSpur(ackSpur)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import pic_pkg::*;
#(
  parameter int N  = PIC_LEVELS,
  parameter int LW = PIC_LVL_W
) (
  input logic         clk,
  input logic         rstN,
  input logic         wrEn,
  input logic         addr,
  input logic [N-1:0] wrData,
  input logic         intAck,
  input logic         irqOut,
  input logic         vecValid,
  input logic [N-1:0] irrQ,
  input logic [N-1:0] isrQ,
  input logic [N-1:0] maskQ,
  input pic_stb_t     stb,
  input logic         irqPend
);
  localparam int EOI_OP = 12;

  assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> (maskQ == '1 && isrQ == '0 && !irqOut));

  assert_irq_unmasked_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((irrQ & ~maskQ) != '0));

  assert_vec_in_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> intAck);

  assert_ack_sets_isr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackFirst && irqPend && !stb.initAll) |=> (isrQ != '0));

  assert_eoi_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && !wrData[4] && wrData[N-1:LW] == (N-LW)'(EOI_OP) && !intAck)
      |=> !isrQ[$past(wrData[LW-1:0])]);

  assert_spurious_no_isr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackFirst && !irqPend && !stb.eoi && !stb.initAll) |=> (isrQ == $past(isrQ)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N(N), .LW(LW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .intAck(intAck), .irqOut(irqOut), .vecValid(vecValid),
  .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ), .stb(stb), .irqPend(irqPend)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] irqReq = '0;
  logic       irqOut;
  logic       intAck = 1'b0;
  logic [7:0] vecOut;
  logic       vecValid;
  logic       slaveMode = 1'b0;
  logic [2:0] casIn = '0;
  logic [2:0] casOut;
  logic       casDrive;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqReq(irqReq), .irqOut(irqOut), .intAck(intAck),
    .vecOut(vecOut), .vecValid(vecValid), .slaveMode(slaveMode),
    .casIn(casIn), .casOut(casOut), .casDrive(casDrive)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic setReq(input logic [7:0] r);
    @(negedge clk);
    irqReq = r;
    @(negedge clk);
  endtask

  task automatic ack(output logic vv, output logic [7:0] vo, output logic cd, output logic [2:0] co);
    @(negedge clk);
    intAck = 1'b1;
    #1;
    vv = vecValid; vo = vecOut; cd = casDrive; co = casOut;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic readIsr(output logic [7:0] d);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
  endtask

  task automatic readIrr(output logic [7:0] d);
    wr(1'b0, 8'h0A);
    rd(1'b0, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    #1;
    chk({7'd0, irqOut}, 8'h00, "R1 irqOut low after reset");
    rd(1'b1, d); chk(d, 8'hFF, "R3 mask after reset");
    rd(1'b0, d); chk(d, 8'h00, "R4 default select is request register");
  endtask

  task automatic t_master_basic;
    logic [7:0] d, vo; logic vv, cd; logic [2:0] co;
    irqReq = 8'h00;
    wr(1'b0, 8'h11);
    chk({7'd0, irqOut}, 8'h00, "R1 irqOut low during init");
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h01);
    rd(1'b1, d); chk(d, 8'hFF, "R1 mask full after init");
    wr(1'b1, 8'hF0);
    rd(1'b1, d); chk(d, 8'hF0, "R3 mask readback");
    setReq(8'h28);
    #1; chk({7'd0, irqOut}, 8'h01, "R5 unmasked level 3 raises irqOut");
    rd(1'b0, d); chk(d, 8'h28, "R4 request register read");
    ack(vv, vo, cd, co);
    chk({7'd0, vv}, 8'h00, "R6 no vector on first pulse");
    ack(vv, vo, cd, co);
    chk({7'd0, vv}, 8'h01, "R6 vector valid on second pulse");
    chk(vo, 8'h23, "R6 vector value level 3");
    readIsr(d); chk(d, 8'h08, "R6 in-service bit 3 set");
    wr(1'b1, 8'h00);
    #1; chk({7'd0, irqOut}, 8'h00, "R5 level 5 blocked by level 3 in service");
    setReq(8'h2A);
    #1; chk({7'd0, irqOut}, 8'h01, "R5 level 1 nests over level 3");
    ack(vv, vo, cd, co);
    ack(vv, vo, cd, co);
    chk(vo, 8'h21, "R6 vector value level 1");
    rd(1'b0, d); chk(d, 8'h0A, "R6 in-service bits 1 and 3");
    readIrr(d); chk(d, 8'h20, "R10 edge requests cleared by ack, held lines not re-requested");
    wr(1'b0, 8'h61);
    readIsr(d); chk(d, 8'h08, "R7 specific EOI clears only bit 1");
    wr(1'b0, 8'h63);
    rd(1'b0, d); chk(d, 8'h00, "R7 specific EOI clears bit 3");
    #1; chk({7'd0, irqOut}, 8'h01, "R5 level 5 unblocked after EOI");
    setReq(8'h00);
    readIrr(d); chk(d, 8'h00, "R10 edge request cleared when line drops");
  endtask

  task automatic t_spurious;
    logic [7:0] d, vo; logic vv, cd; logic [2:0] co;
    setReq(8'h10);
    #1; chk({7'd0, irqOut}, 8'h01, "R5 level 4 raises irqOut");
    setReq(8'h00);
    ack(vv, vo, cd, co);
    ack(vv, vo, cd, co);
    chk({7'd0, vv}, 8'h01, "R9 spurious vector supplied");
    chk(vo, 8'h27, "R9 spurious vector is level 7");
    readIsr(d); chk(d, 8'h00, "R9 spurious leaves in-service clear");
    wr(1'b1, 8'hFF);
    ack(vv, vo, cd, co);
    ack(vv, vo, cd, co);
    chk(vo, 8'h27, "R9 spurious vector with full mask");
    rd(1'b0, d); chk(d, 8'h00, "R9 in-service clear with full mask");
  endtask

  task automatic t_cascade_master;
    logic [7:0] vo; logic vv, cd; logic [2:0] co;
    wr(1'b1, 8'h00);
    setReq(8'h04);
    ack(vv, vo, cd, co);
    chk({7'd0, cd}, 8'h01, "R11 cascade drive on first pulse");
    chk({5'd0, co}, 8'h02, "R11 cascade id 2 on first pulse");
    ack(vv, vo, cd, co);
    chk({7'd0, cd}, 8'h01, "R11 cascade drive on second pulse");
    chk({5'd0, co}, 8'h02, "R11 cascade id 2 on second pulse");
    chk({7'd0, vv}, 8'h00, "R11 master supplies no vector for slave input");
    wr(1'b0, 8'h62);
    setReq(8'h00);
  endtask

  task automatic t_aeoi_level;
    logic [7:0] d, vo; logic vv, cd; logic [2:0] co;
    wr(1'b0, 8'h1B);
    wr(1'b1, 8'h48);
    wr(1'b1, 8'h02);
    wr(1'b1, 8'h00);
    rd(1'b1, d); chk(d, 8'h00, "R2 cascade word skipped in single mode");
    setReq(8'h40);
    ack(vv, vo, cd, co);
    chk({7'd0, cd}, 8'h00, "R11 no cascade drive in single mode");
    ack(vv, vo, cd, co);
    chk(vo, 8'h4E, "R6 vector value level 6 with new base");
    readIsr(d); chk(d, 8'h00, "R8 automatic EOI clears in-service");
    #1; chk({7'd0, irqOut}, 8'h01, "R10 level mode re-requests while line high");
    setReq(8'h00);
    #1; chk({7'd0, irqOut}, 8'h00, "R10 level mode request follows line low");
  endtask

  task automatic t_no_mode_word;
    logic [7:0] d;
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h80);
    wr(1'b1, 8'h5A);
    rd(1'b1, d); chk(d, 8'h5A, "R2 sequence ends after base without mode word");
  endtask

  task automatic t_slave;
    logic [7:0] d, vo; logic vv, cd; logic [2:0] co;
    slaveMode = 1'b1;
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h70);
    wr(1'b1, 8'h02);
    wr(1'b1, 8'h01);
    wr(1'b1, 8'h00);
    setReq(8'h01);
    casIn = 3'd3;
    ack(vv, vo, cd, co);
    chk({7'd0, vv}, 8'h00, "R12 slave ignores other identity");
    readIsr(d); chk(d, 8'h00, "R12 slave in-service unchanged for other identity");
    casIn = 3'd2;
    ack(vv, vo, cd, co);
    ack(vv, vo, cd, co);
    chk({7'd0, vv}, 8'h01, "R12 slave supplies vector for its identity");
    chk(vo, 8'h70, "R12 slave vector level 0");
    setReq(8'h00);
    slaveMode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_master_basic;
    t_spurious;
    t_cascade_master;
    t_aeoi_level;
    t_no_mode_word;
    t_slave;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule